// File: doc/BRIEF.md
# Multiprocessor Barrier and Shared-Memory Bus Controller

This block sits between a small group of processor cores (one, two or four, set by a parameter) and the single external memory port they share. It decides which core owns that port, under a fixed priority in which core 0, the main core, always wins and the highest-numbered core always loses. It drives the select inputs of the address and data multiplexers in front of the port. A granted transfer is never taken away while the owning core keeps requesting.

The same block sequences parallel execution. Outside a parallel region only the main core runs, and the other cores are held stopped. A single-cycle start pulse from the main core opens a region and lets every core run. A single-cycle end pulse closes it again. Inside a region, a core that reaches a synchronisation point raises a one-cycle barrier pulse and is stopped. When every participating core has arrived, the block releases them all together and gives the main core a one-cycle sync pulse. Requests and barrier pulses from cores that are stopped outside a region are ignored.

Top module: `mp_sync_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows grant_oh all zero, sel_valid 0, sync_pulse 0 and core_run equal to 1 in bit 0 only, and no parallel region is open.
- R2: When the port is free, the next grant goes to the lowest-numbered eligible requester. The grant appears on grant_oh one cycle after the request edge, and grant_oh is zero or one-hot.
- R3: A core keeps the grant for as long as it holds its request and stays eligible; a higher-priority request does not pre-empt it. At the edge where the holder drops its request, arbitration runs again and a new holder can be granted on that same edge.
- R4: sel_valid is high exactly when grant_oh is non-zero, and data_sel and addr_sel both carry the binary index of the granted core.
- R5: Outside a parallel region core_run bits 1 and up are 0. A region_start pulse makes them 1 in the cycle after that edge.
- R6: A region_end pulse clears core_run bits 1 and up in the cycle after that edge. When region_start and region_end arrive together, the end wins.
- R7: A participating core that pulses its barr_pulse bit, without being the last to arrive, has its core_run bit at 0 from the next cycle until the release.
- R8: In the cycle after the edge at which the last participating core arrives, sync_pulse is 1 for exactly one cycle and every participating core's core_run bit is 1.
- R9: Outside a region only the main core participates: its barrier alone yields sync_pulse in the next cycle, and barrier pulses from cores 1 and up are ignored.
- R10: A request from core 1 or up is eligible only while a region is open, as seen at the arbitration edge. When the region closes, a secondary core holding the grant loses it at the next arbitration edge.
- R11: After a release, all arrival flags start cleared, so one core's later barrier does not produce sync_pulse by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | input | N_CORES | Per-core external memory request, held for the length of a transfer |
| barr_pulse | input | N_CORES | One-cycle pulse from a core reaching a barrier |
| region_start | input | 1 | One-cycle pulse from the main core opening a parallel region |
| region_end | input | 1 | One-cycle pulse from the main core closing the parallel region |
| grant_oh | output | N_CORES | One-hot grant of the external port |
| data_sel | output | SEL_W | Select for the data multiplexer |
| addr_sel | output | SEL_W | Select for the address multiplexer |
| sel_valid | output | 1 | A core owns the port |
| core_run | output | N_CORES | Per-core permission to execute |
| sync_pulse | output | 1 | One-cycle release notice to the main core |

## Verification
Every result is due one clock edge after its stimulus. A grant follows the request edge. Core_run follows a start, end or barrier edge, and sync_pulse follows the last arrival edge. The selects follow the grant combinationally, in the same cycle. The bench applies each vector just after a rising edge, lets exactly one edge pass, and compares all outputs one time unit later, so each expected value belongs to a single edge. The vector walk is stateful: each row's expectation accounts for the region and arrival state that earlier rows left behind.

// File: rtl/mpc_pkg.sv
// Package: shared helpers for the multiprocessor sync controller.
// Assumes core counts are small (1, 2 or 4).
package mpc_pkg;
    // Width of a binary core index; at least one bit.
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mpc_region.sv
// mpc_region: tracks whether a parallel region is open and derives the
// mask of cores that participate in barriers and arbitration.
// Assumes start/end arrive as one-cycle pulses from the main core.
module mpc_region #(
    parameter int N_CORES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               region_start,
    input  logic               region_end,
    output logic               par,
    output logic [N_CORES-1:0] part
);
    logic par_q;

    // Region flag: end has priority over start.
    always_ff @(posedge clk) begin
        if (!rst_n)            par_q <= 1'b0;
        else if (region_end)   par_q <= 1'b0;
        else if (region_start) par_q <= 1'b1;
    end

    assign par = par_q;

    // Participation mask: main core always, others only inside a region.
    if (N_CORES > 1) begin : g_multi
        assign part = {{(N_CORES-1){par_q}}, 1'b1};
    end else begin : g_single
        assign part = 1'b1;
    end
endmodule

// File: rtl/mpc_barrier.sv
// mpc_barrier: collects barrier arrivals from participating cores and
// fires a one-cycle sync once all have arrived, clearing every flag.
// Assumes barrier requests are one-cycle pulses.
module mpc_barrier #(
    parameter int N_CORES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] barr,
    input  logic [N_CORES-1:0] part,
    output logic [N_CORES-1:0] halted,
    output logic               sync
);
    logic [N_CORES-1:0] arr_q;
    logic [N_CORES-1:0] arr_next;
    logic               all_in;
    logic               sync_q;

    // Next arrival set, masked to the participating cores.
    always_comb begin
        arr_next = (arr_q | barr) & part;
        all_in   = &(arr_next | ~part);
    end

    // Arrival flags and sync pulse: release clears everything at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_q  <= '0;
            sync_q <= 1'b0;
        end else if (all_in && (|arr_next)) begin
            arr_q  <= '0;
            sync_q <= 1'b1;
        end else begin
            arr_q  <= arr_next;
            sync_q <= 1'b0;
        end
    end

    assign halted = arr_q;
    assign sync   = sync_q;
endmodule

// File: rtl/mpc_arb.sv
// mpc_arb: fixed-priority, non-preemptive arbiter for the shared port.
// Lowest index wins; the holder keeps the grant while it requests and
// stays eligible. Assumes requests are held for a whole transfer.
module mpc_arb #(
    parameter int N_CORES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] req,
    input  logic [N_CORES-1:0] elig,
    output logic [N_CORES-1:0] gnt
);
    logic [N_CORES-1:0] gnt_q;
    logic [N_CORES-1:0] cand;
    logic [N_CORES-1:0] pick;
    logic               keep;

    // Choose the lowest-numbered eligible requester.
    always_comb begin
        cand = req & elig;
        keep = |(gnt_q & cand);
        pick = '0;
        for (int i = N_CORES-1; i >= 0; i--) begin
            if (cand[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    // Grant register: re-arbitrate only when the holder lets go.
    always_ff @(posedge clk) begin
        if (!rst_n)    gnt_q <= '0;
        else if (!keep) gnt_q <= pick;
    end

    assign gnt = gnt_q;
endmodule

// File: rtl/mp_sync_ctrl.sv
// mp_sync_ctrl: shared-memory bus and parallel-execution controller.
// Arbitrates the external port, drives mux selects, runs the
// start/end region handshake and the all-arrived barrier.
// Assumes N_CORES is 1, 2 or 4 and all control inputs are synchronous.
module mp_sync_ctrl #(
    parameter int N_CORES = 4,
    localparam int SEL_W  = mpc_pkg::sel_width(N_CORES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] mem_req,
    input  logic [N_CORES-1:0] barr_pulse,
    input  logic               region_start,
    input  logic               region_end,
    output logic [N_CORES-1:0] grant_oh,
    output logic [SEL_W-1:0]   data_sel,
    output logic [SEL_W-1:0]   addr_sel,
    output logic               sel_valid,
    output logic [N_CORES-1:0] core_run,
    output logic               sync_pulse
);
    logic               par;
    logic [N_CORES-1:0] part;
    logic [N_CORES-1:0] halted;
    logic [SEL_W-1:0]   idx;

    mpc_region #(.N_CORES(N_CORES)) u_region (
        .clk(clk), .rst_n(rst_n),
        .region_start(region_start), .region_end(region_end),
        .par(par), .part(part)
    );

    mpc_barrier #(.N_CORES(N_CORES)) u_barrier (
        .clk(clk), .rst_n(rst_n),
        .barr(barr_pulse), .part(part),
        .halted(halted), .sync(sync_pulse)
    );

    mpc_arb #(.N_CORES(N_CORES)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .req(mem_req), .elig(part),
        .gnt(grant_oh)
    );

    // Encode the one-hot grant into a binary mux select.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N_CORES; i++) begin
            if (grant_oh[i]) idx = idx | SEL_W'(i);
        end
    end

    assign data_sel  = idx;
    assign addr_sel  = idx;
    assign sel_valid = |grant_oh;

    // A core runs when it participates and is not waiting at a barrier.
    assign core_run = part & ~halted;
endmodule

// File: rtl/mp_sync_ctrl_chk.sv
// mp_sync_ctrl_chk: property checker bound to mp_sync_ctrl.
module mp_sync_ctrl_chk #(
    parameter int N_CORES = 4,
    parameter int SEL_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CORES-1:0] mem_req,
    input logic [N_CORES-1:0] grant_oh,
    input logic [SEL_W-1:0]   data_sel,
    input logic               sel_valid,
    input logic [N_CORES-1:0] core_run,
    input logic               sync_pulse,
    input logic               par
);
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh));

    p_no_preempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_oh[0] && mem_req[0]) |=> grant_oh[0]);

    p_sel_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> grant_oh[data_sel]);

    p_idle_secondary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !par |-> ((core_run >> 1) == '0));

    p_sync_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);

    p_sync_main_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> core_run[0]);

    p_no_idle_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!par && $past(!par)) |-> ((grant_oh >> 1) == '0));
endmodule

bind mp_sync_ctrl mp_sync_ctrl_chk #(.N_CORES(N_CORES), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .grant_oh(grant_oh),
    .data_sel(data_sel), .sel_valid(sel_valid), .core_run(core_run),
    .sync_pulse(sync_pulse), .par(par)
);

// File: tb/mp_sync_ctrl_test.sv
module mp_sync_ctrl_test;
    localparam int N = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  mem_req = '0;
    logic [N-1:0]  barr_pulse = '0;
    logic          region_start = 1'b0;
    logic          region_end = 1'b0;
    logic [N-1:0]  grant_oh;
    logic [SW-1:0] data_sel;
    logic [SW-1:0] addr_sel;
    logic          sel_valid;
    logic [N-1:0]  core_run;
    logic          sync_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mp_sync_ctrl #(.N_CORES(N)) uut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .barr_pulse(barr_pulse),
        .region_start(region_start), .region_end(region_end),
        .grant_oh(grant_oh), .data_sel(data_sel), .addr_sel(addr_sel),
        .sel_valid(sel_valid), .core_run(core_run), .sync_pulse(sync_pulse)
    );

    // {start, end, req, barr, exp_grant, exp_run, exp_sync}
    localparam int NV = 23;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0,1'b0,4'b1110,4'b0000, 4'b0000,4'b0001,1'b0}, // R10 idle secondaries ignored
        {1'b0,1'b0,4'b1111,4'b0000, 4'b0001,4'b0001,1'b0}, // R2 main wins
        {1'b1,1'b0,4'b1111,4'b0000, 4'b0001,4'b1111,1'b0}, // R5 start, R3 keep
        {1'b0,1'b0,4'b1110,4'b0000, 4'b0010,4'b1111,1'b0}, // R3 rearbitrate -> core1
        {1'b0,1'b0,4'b1100,4'b0000, 4'b0100,4'b1111,1'b0}, // R2 core2
        {1'b0,1'b0,4'b0110,4'b0000, 4'b0100,4'b1111,1'b0}, // R3 no preemption
        {1'b0,1'b0,4'b0010,4'b0000, 4'b0010,4'b1111,1'b0}, // R3
        {1'b0,1'b0,4'b0000,4'b0000, 4'b0000,4'b1111,1'b0}, // R4 idle port
        {1'b0,1'b0,4'b0000,4'b0010, 4'b0000,4'b1101,1'b0}, // R7 core1 halts
        {1'b0,1'b0,4'b0000,4'b1000, 4'b0000,4'b0101,1'b0}, // R7 core3 halts
        {1'b0,1'b0,4'b0000,4'b0001, 4'b0000,4'b0100,1'b0}, // R7 main halts
        {1'b0,1'b0,4'b0000,4'b0100, 4'b0000,4'b1111,1'b1}, // R8 release
        {1'b0,1'b0,4'b0000,4'b0000, 4'b0000,4'b1111,1'b0}, // R8 single pulse
        {1'b0,1'b0,4'b0000,4'b0010, 4'b0000,4'b1101,1'b0}, // R11 fresh barrier
        {1'b0,1'b0,4'b0000,4'b0000, 4'b0000,4'b1101,1'b0}, // R11 no sync
        {1'b0,1'b1,4'b0000,4'b0000, 4'b0000,4'b0001,1'b0}, // R6 end
        {1'b0,1'b0,4'b0110,4'b1110, 4'b0000,4'b0001,1'b0}, // R9 R10 ignored
        {1'b0,1'b0,4'b0000,4'b0001, 4'b0000,4'b0001,1'b1}, // R9 main-only barrier
        {1'b1,1'b1,4'b0000,4'b0000, 4'b0000,4'b0001,1'b0}, // R6 end wins
        {1'b1,1'b0,4'b0100,4'b0000, 4'b0000,4'b1111,1'b0}, // R10 eligibility at edge
        {1'b0,1'b0,4'b0100,4'b0000, 4'b0100,4'b1111,1'b0}, // R2 core2
        {1'b0,1'b1,4'b0100,4'b0000, 4'b0100,4'b0001,1'b0}, // R6 end, R3 keep
        {1'b0,1'b0,4'b0100,4'b0000, 4'b0000,4'b0001,1'b0}  // R10 holder dropped
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_outputs(input logic [3:0] eg, input logic [3:0] er, input logic es);
        int ei = 0;
        for (int k = 0; k < N; k++) if (eg[k]) ei = k;
        chk("R2/R3/R10 grant", int'(grant_oh), int'(eg));
        chk("R5/R6/R7/R11 run", int'(core_run), int'(er));
        chk("R8/R9 sync", int'(sync_pulse), int'(es));
        chk("R4 sel_valid", int'(sel_valid), int'(eg != 0));
        if (eg != 0) begin
            chk("R4 data_sel", int'(data_sel), ei);
            chk("R4 addr_sel", int'(addr_sel), ei);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_outputs(4'b0000, 4'b0001, 1'b0); // R1 reset state
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            {region_start, region_end, mem_req, barr_pulse} = VEC[v][18:9];
            @(posedge clk);
            #1;
            chk_outputs(VEC[v][8:5], VEC[v][4:1], VEC[v][0]);
        end
        // R1: reset in the middle of activity
        {region_start, region_end, mem_req, barr_pulse} = {1'b1, 1'b0, 4'b1111, 4'b0000};
        @(posedge clk);
        #1;
        chk("R1 pre-reset grant", int'(grant_oh), 1);
        region_start = 1'b0;
        barr_pulse   = 4'b0010;
        rst_n        = 1'b0;
        @(posedge clk);
        #1;
        chk_outputs(4'b0000, 4'b0001, 1'b0);
        rst_n = 1'b1;
        mem_req = '0;
        barr_pulse = '0;
        @(posedge clk);
        #1;
        chk("R1 stays idle", int'(core_run), 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule